// File: doc/BRIEF.md
# Four-Level Page Table Walker

After a translation lookaside miss, this block translates a virtual page number into a physical page number. It walks a radix page table with four levels, held in memory. The requester gives a 36-bit virtual page number on a valid/ready handshake. At the same moment the block latches the frame number of the top-level table. It then reads one 64-bit entry per level. At every level it uses a 9-bit slice of the page number, starting with the most significant slice.

Every entry it reads is tested for presence. A present entry at an upper level gives the frame of the next table. A present entry at the last level gives the 40-bit physical page number. An entry that is not present stops the walk at once. The block then returns a fault that names the level, from 1 to 4, where the walk stopped. A result is held on the response port until the requester takes it. The block then goes back to idle and accepts the next walk.

Top module: `ptWalker`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memReqValid is 0.
- R2: The read for level k (k = 1..4) goes to byte address base*4096 + idx_k*8. idx_1 is vpn[35:27], idx_2 is vpn[26:18], idx_3 is vpn[17:9] and idx_4 is vpn[8:0]. base is the root frame for level 1 and the frame from the previous entry for the later levels.
- R3: memReqValid is high for exactly one cycle per level. The next read is not issued until memRspValid has returned the entry.
- R4: Bit 0 of an entry is the present bit, and bits 51:12 hold a frame number. Bits 63:52 and 11:1 have no effect.
- R5: When all four entries are present, the response has rspFault=0 and rspLevel=0, and rspPpn equals bits 51:12 of the level-4 entry.
- R6: An entry with bit 0 clear at level k ends the walk. The response has rspFault=1 and rspLevel=k, and no further read is issued.
- R7: A request is accepted only in idle. While a walk is in progress reqReady is 0, and reqValid has no effect.
- R8: rspValid and its fields stay stable until rspReady is sampled high. The block is then idle in the next cycle.
- R9: rootBase is sampled only when a request is accepted. Later changes do not alter the addresses of the walk.
- R10: memRspValid has no effect while no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request valid |
| reqReady | output | 1 | Walker is idle and can accept a request |
| reqVpn | input | 36 | Virtual page number to translate |
| rootBase | input | 40 | Frame number of the top-level table |
| rspValid | output | 1 | Walk result valid |
| rspReady | input | 1 | Requester takes the result |
| rspFault | output | 1 | Walk ended on a non-present entry |
| rspLevel | output | 3 | Level of the faulting entry (1..4), 0 on success |
| rspPpn | output | 40 | Translated physical page number |
| memReqValid | output | 1 | One-cycle read strobe |
| memReqAddr | output | 52 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry returned by memory |

## Verification
Directed walks cover four cases: a full translation, a fault at each of the four levels, an all-zero and an all-ones page number, and the extreme root frames. These show whether the slicing, the level count in the fault tag and the point where the walk stops are each correct. Random walks add random entries with junk in the unused bits, a random memory latency, and random response back-pressure. These tell apart a design that decodes the frame field correctly from one that lets stray bits through, and a single-issue design from one that repeats reads. During every walk, the bench moves rootBase and raises reqValid, and it sends stray read responses while the block is idle. These show whether the sampling point and the outstanding-read guard are correct.

// File: rtl/ptwPkg.sv
package ptwPkg;

  localparam int LEVELS = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L1    = 3'd1,
    ST_L2    = 3'd2,
    ST_L3    = 3'd3,
    ST_L4    = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadReq;   // capture vpn and root frame
    logic       loadBase;  // next table frame from entry
    logic       loadPpn;   // final page number from entry
    logic [1:0] levelSel;  // which index slice addresses memory
  } walkCtrl_t;

endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int PPN_W   = 40,
  parameter int ENTRY_W = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  walkCtrl_t                          ctrl,
  input  logic [LEVELS*IDX_W-1:0]            reqVpn,
  input  logic [PPN_W-1:0]                   rootBase,
  input  logic [ENTRY_W-1:0]                 memRspData,
  output logic [PPN_W+IDX_W+2:0]             memReqAddr,
  output logic                               entryPresent,
  output logic [PPN_W-1:0]                   rspPpn
);

  localparam int ENTRY_SH = 3;                 // 8-byte entries
  localparam int PAGE_W   = IDX_W + ENTRY_SH;  // 4 KB tables
  localparam int VPN_W    = LEVELS * IDX_W;

  logic [VPN_W-1:0] vpnQ;
  logic [PPN_W-1:0] baseQ;
  logic [PPN_W-1:0] ppnQ;
  logic [IDX_W-1:0] idxArr [LEVELS];
  logic [IDX_W-1:0] curIdx;
  logic [PPN_W-1:0] entryFrame;
  logic             unusedBits;

  // most significant slice serves the first level
  for (genvar i = 0; i < LEVELS; i++) begin : g_slice
    assign idxArr[i] = vpnQ[VPN_W-1-i*IDX_W -: IDX_W];
  end

  assign curIdx       = idxArr[ctrl.levelSel];
  assign memReqAddr   = {baseQ, curIdx, {ENTRY_SH{1'b0}}};
  assign entryPresent = memRspData[0];
  assign entryFrame   = memRspData[PAGE_W +: PPN_W];
  assign unusedBits   = ^{memRspData[ENTRY_W-1:PAGE_W+PPN_W], memRspData[PAGE_W-1:1]};
  assign rspPpn       = ppnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ  <= '0;
      baseQ <= '0;
      ppnQ  <= '0;
    end else begin
      if (ctrl.loadReq) begin
        vpnQ  <= reqVpn;
        baseQ <= rootBase;
      end else if (ctrl.loadBase) begin
        baseQ <= entryFrame;
      end
      if (ctrl.loadPpn) ppnQ <= entryFrame;
    end
  end

  // R7: a new request is never captured in the cycle an entry is consumed
  p_no_load_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadBase || ctrl.loadPpn) |-> !ctrl.loadReq);

  // R4: a frame is only taken from a present entry
  p_frame_needs_present_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadBase || ctrl.loadPpn) |-> entryPresent);

endmodule

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptwPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  output logic      rspFault,
  output logic [2:0] rspLevel,
  output logic      memReqValid,
  input  logic      memRspValid,
  input  logic      entryPresent,
  output walkCtrl_t ctrl
);

  walkState_t state, nextState;
  logic       issued;
  logic [2:0] faultLvl;
  logic       inWalk;
  logic       lastLevel;
  logic       respTake;
  logic [1:0] levelSel;

  always_comb begin
    case (state)
      ST_L1:   levelSel = 2'd0;
      ST_L2:   levelSel = 2'd1;
      ST_L3:   levelSel = 2'd2;
      ST_L4:   levelSel = 2'd3;
      default: levelSel = 2'd0;
    endcase
  end

  assign inWalk      = (state == ST_L1) || (state == ST_L2) ||
                       (state == ST_L3) || (state == ST_L4);
  assign lastLevel   = (state == ST_L4);
  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = inWalk && !issued;
  assign respTake    = inWalk && issued && memRspValid;
  assign rspValid    = (state == ST_DONE) || (state == ST_FAULT);
  assign rspFault    = (state == ST_FAULT);
  assign rspLevel    = (state == ST_FAULT) ? faultLvl : 3'd0;

  always_comb begin
    ctrl.loadReq  = reqReady && reqValid;
    ctrl.loadBase = respTake && entryPresent && !lastLevel;
    ctrl.loadPpn  = respTake && entryPresent && lastLevel;
    ctrl.levelSel = levelSel;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) nextState = ST_L1;
      ST_L1, ST_L2, ST_L3, ST_L4: begin
        if (respTake) begin
          if (!entryPresent)  nextState = ST_FAULT;
          else if (lastLevel) nextState = ST_DONE;
          else                nextState = walkState_t'(state + 3'd1);
        end
      end
      ST_DONE, ST_FAULT: if (rspReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      issued   <= 1'b0;
      faultLvl <= 3'd0;
    end else begin
      state <= nextState;
      if (respTake || !inWalk) issued <= 1'b0;
      else if (memReqValid)    issued <= 1'b1;
      if (respTake && !entryPresent) faultLvl <= {1'b0, levelSel} + 3'd1;
    end
  end

  // R3: a read strobe never repeats in the following cycle
  p_single_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R8: an unaccepted result stays put
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspFault) && $stable(rspLevel)));

  // R6: a fault always names a level from 1 to 4
  p_fault_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspLevel >= 3'd1 && rspLevel <= 3'd4));

  // R6: no read while a result is pending
  p_no_read_on_rsp_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memReqValid);

  // R7: the walker never reports ready while a result is pending
  p_busy_on_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptwPkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int PPN_W   = 40,
  parameter int ENTRY_W = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [LEVELS*IDX_W-1:0]       reqVpn,
  input  logic [PPN_W-1:0]              rootBase,
  output logic                          rspValid,
  input  logic                          rspReady,
  output logic                          rspFault,
  output logic [2:0]                    rspLevel,
  output logic [PPN_W-1:0]              rspPpn,
  output logic                          memReqValid,
  output logic [PPN_W+IDX_W+2:0]        memReqAddr,
  input  logic                          memRspValid,
  input  logic [ENTRY_W-1:0]            memRspData
);

  walkCtrl_t ctrl;
  logic      entryPresent;

  ptwCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .rspValid     (rspValid),
    .rspReady     (rspReady),
    .rspFault     (rspFault),
    .rspLevel     (rspLevel),
    .memReqValid  (memReqValid),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .ctrl         (ctrl)
  );

  ptwDatapath #(
    .IDX_W   (IDX_W),
    .PPN_W   (PPN_W),
    .ENTRY_W (ENTRY_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .reqVpn       (reqVpn),
    .rootBase     (rootBase),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .entryPresent (entryPresent),
    .rspPpn       (rspPpn)
  );

  // R8: translated page number holds until taken
  p_ppn_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> $stable(rspPpn));

  // R1: nothing is pending in the cycle a request is accepted
  p_accept_clean_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!rspValid && !memReqValid));

endmodule

// File: tb/tb_ptWalker.sv
module tb_ptWalker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, rspValid, rspReady, rspFault;
  logic [35:0] reqVpn;
  logic [39:0] rootBase, rspPpn;
  logic [2:0]  rspLevel;
  logic        memReqValid, memRspValid;
  logic [51:0] memReqAddr;
  logic [63:0] memRspData;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ptWalker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVpn(reqVpn), .rootBase(rootBase), .rspValid(rspValid), .rspReady(rspReady),
    .rspFault(rspFault), .rspLevel(rspLevel), .rspPpn(rspPpn),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [51:0] expAddr(input logic [39:0] base, input logic [35:0] vpn, input int lvl);
    logic [8:0] idx;
    idx = vpn[35 - 9*(lvl-1) -: 9];
    return {base, idx, 3'b000};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // stray response while idle must change nothing (R10)
  task automatic strayResp();
    memRspValid = 1'b1;
    memRspData  = rnd64() | 64'h1;
    @(negedge clk);
    memRspValid = 1'b0;
    @(negedge clk);
    chk(reqReady && !rspValid && !memReqValid, "R10 stray response ignored",
        {61'd0, reqReady, rspValid, memReqValid}, 64'h4);
  endtask

  // one walk; faultAt = 0 for a full translation, else level whose entry is absent
  task automatic runWalk(input logic [35:0] vpn, input logic [39:0] root, input int faultAt);
    logic [63:0] ent [1:4];
    logic [39:0] base;
    int stopLvl;
    for (int l = 1; l <= 4; l++) begin
      ent[l] = rnd64();
      ent[l][0] = (l == faultAt) ? 1'b0 : 1'b1;
    end
    base = root;
    stopLvl = 0;
    chk(reqReady, "R7 ready before walk", {63'd0, reqReady}, 64'd1);
    reqValid = 1'b1; reqVpn = vpn; rootBase = root;
    @(negedge clk);
    reqValid = 1'b0;
    rootBase = rnd64()[39:0]; // R9: must not matter any more
    for (int lvl = 1; lvl <= 4; lvl++) begin
      int n = 0;
      int lat;
      while (!memReqValid && n < 10) begin
        @(negedge clk);
        n++;
      end
      chk(memReqValid, "R3 read issued per level", {63'd0, memReqValid}, 64'd1);
      chk(memReqAddr == expAddr(base, vpn, lvl), "R2 R9 entry address",
          {12'd0, memReqAddr}, {12'd0, expAddr(base, vpn, lvl)});
      lat = 1 + int'($urandom % 3);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(!memReqValid, "R3 no repeat read", {63'd0, memReqValid}, 64'd0);
        chk(!reqReady, "R7 busy during walk", {63'd0, reqReady}, 64'd0);
        reqValid = 1'b1;           // R7: ignored while busy
        reqVpn   = rnd64()[35:0];
      end
      reqValid    = 1'b0;
      memRspValid = 1'b1;
      memRspData  = ent[lvl];
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = rnd64();
      if (!ent[lvl][0]) begin
        stopLvl = lvl;
        break;
      end
      base = ent[lvl][51:12];
    end
    chk(rspValid, "R5 R6 result valid", {63'd0, rspValid}, 64'd1);
    chk(!memReqValid, "R6 no read after end", {63'd0, memReqValid}, 64'd0);
    if (stopLvl != 0) begin
      chk(rspFault && rspLevel == 3'(stopLvl), "R6 fault level",
          {60'd0, rspFault, rspLevel}, {60'd0, 1'b1, 3'(stopLvl)});
    end else begin
      chk(!rspFault && rspLevel == 3'd0, "R5 success flags",
          {60'd0, rspFault, rspLevel}, 64'd0);
      chk(rspPpn == ent[4][51:12], "R4 R5 final page number",
          {24'd0, rspPpn}, {24'd0, ent[4][51:12]});
    end
    begin
      logic [43:0] snap;
      int hold;
      snap = {rspFault, rspLevel, rspPpn};
      hold = int'($urandom % 3);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(rspValid && {rspFault, rspLevel, rspPpn} == snap, "R8 result held",
            {19'd0, rspValid, rspFault, rspLevel, rspPpn}, {19'd0, 1'b1, snap});
      end
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R8 back to idle", {62'd0, rspValid, reqReady}, 64'd1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; reqValid = 1'b0; rspReady = 1'b0; memRspValid = 1'b0;
    reqVpn = '0; rootBase = '0; memRspData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(reqReady && !rspValid && !memReqValid, "R1 reset state",
        {61'd0, reqReady, rspValid, memReqValid}, 64'h4);
    strayResp();
    // directed corner cases
    runWalk(36'h123456789, 40'h00000_00100, 0);
    for (int f = 1; f <= 4; f++) runWalk(36'hABCDE_F012, 40'h12345_6789A, f);
    runWalk(36'h0_0000_0000, 40'h00000_00000, 0);
    runWalk(36'hF_FFFF_FFFF, 40'hFFFFF_FFFFF, 0);
    strayResp();
    // random walks
    for (int t = 0; t < 60; t++) begin
      int fa;
      fa = ($urandom % 3 == 0) ? 1 + int'($urandom % 4) : 0;
      runWalk(rnd64()[35:0], rnd64()[39:0], fa);
      if ($urandom % 4 == 0) strayResp();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule